// File: doc/BRIEF.md
# Shift-Down Conversion Result Queue

This block holds converter results until a host processor collects them. It has eight storage slots. Each slot holds a 13-bit word: a 12-bit sample value and a flag that marks the sample as out of range. A finished result goes into the lowest free slot, just above the newest stored word. The host always reads the word in slot 0. After each read, every stored word moves one slot down and the free slot at the top fills with zeros. The read port therefore never moves, and the oldest word is always at the bottom.

The converter, the block and the host all run on one clock. The converter gives a one-cycle result strobe with its value and flag. The host gives a one-cycle read strobe while it samples the bottom word. The block also reports the number of stored words, empty and full flags, and a sticky flag that records a result lost because the queue was full. The depth and the value width are parameters and are checked when the design is elaborated.

Top module: `shift_result_fifo`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, `ovf_lost` is 0, and the bottom word (`bot_val`, `bot_oor`) is all zeros.
- R2: The out-of-range flag given with a result (`res_oor`) comes back on `bot_oor` together with that result's value, once the word reaches slot 0.
- R3: A result taken when no read happens goes into slot `level`, and `level` goes up by one in the next cycle. A load into a non-empty queue does not change the bottom word.
- R4: A read strobe while the queue is not empty returns the slot 0 word in that cycle. In the next cycle the former slot 1 word is at the bottom and `level` is one lower. Words leave in the order they arrived.
- R5: A load and a read in the same cycle on a queue that holds 1 to 7 words apply the shift and the load together. The new word lands at slot `level-1` after the shift, and `level` does not change.
- R6: A load while `level` is 8 and no read is given is dropped. The stored words stay unchanged and `ovf_lost` goes to 1 in the next cycle. It stays at 1 until the cycle after the next read strobe, and that read clears it.
- R7: While the queue is empty, the bottom word is zero. A read strobe on an empty queue leaves `level` at 0.
- R8: `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is 8. `level` never goes above 8.
- R9: A load and a read in the same cycle on a full queue are both accepted. `level` stays at 8 and `ovf_lost` does not get set.
- R10: A load and a read in the same cycle on an empty queue store the word and ignore the read. `level` becomes 1 and the new word is at the bottom.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for the converter, the queue and the host |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe: a finished result is present |
| res_val | input | VAL_W (12) | Result value |
| res_oor | input | 1 | Out-of-range flag for the result |
| rd_strobe | input | 1 | Host read; the bottom word is taken in this cycle |
| bot_val | output | VAL_W (12) | Value in slot 0, or zero when empty |
| bot_oor | output | 1 | Out-of-range flag in slot 0, or zero when empty |
| level | output | $clog2(DEPTH+1) (4) | Number of stored words |
| empty | output | 1 | No word stored |
| full | output | 1 | All DEPTH slots hold a word |
| ovf_lost | output | 1 | Sticky: a result was dropped since the last read |

## Verification
The main function is exercised with several input patterns, and each one rules out a different class of fault.
- Short bursts of loads followed by reads check ordering and shifting. They show whether words move down one slot per read, not zero or two, and whether each flag stays with its own value.
- Filling the queue to the top and loading once more checks where the load logic stops accepting words and when the sticky loss flag sets and clears.
- Loads and reads in the same cycle are applied at an empty, a partly filled and a full queue. These three cases tell apart the three ways the shifted and loaded slot index can be worked out.
- A long pseudo-random mix of strobes covers sequences that the directed cases miss.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   localparam int unsigned SDF_DEF_VAL_W = 12;
   localparam int unsigned SDF_DEF_DEPTH = 8;

   // per-cycle action of the queue: bit 1 = load accepted, bit 0 = pop taken
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_LOAD = 2'b10,
      OP_BOTH = 2'b11
   } sdf_op_e;

   function automatic logic op_loads(input sdf_op_e op);
      return op[1];
   endfunction

   function automatic logic op_pops(input sdf_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/sdf_cell.sv
module sdf_cell #(
   parameter int unsigned WORD_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift,
   input  logic              load,
   input  logic [WORD_W-1:0] upper,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] q
);

   // load wins: the loaded slot index is already the post-shift position
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
      else if (shift)
         q <= upper;
   end

endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
   import sdf_pkg::*;
#(
   parameter int unsigned DEPTH = SDF_DEF_DEPTH,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             ovf_lost,
   output sdf_op_e          op,
   output logic [LVL_W-1:0] load_idx
);

   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

   logic do_pop;
   logic do_load;

   assign empty   = (level == '0);
   assign full    = (level == LVL_MAX);
   assign do_pop  = rd && !empty;
   assign do_load = wr && (!full || do_pop);
   assign op      = sdf_op_e'({do_load, do_pop});

   // a combined load and pop writes one slot lower, into the slot that the shift frees
   assign load_idx = do_pop ? (level - LVL_ONE) : level;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         unique case (op)
            OP_LOAD: level <= level + LVL_ONE;
            OP_POP:  level <= level - LVL_ONE;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf_lost <= 1'b0;
      else if (rd)
         ovf_lost <= 1'b0;
      else if (wr && full)
         ovf_lost <= 1'b1;
   end

   assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_MAX);

   assert_pop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !empty && !wr) |=> (level == $past(level) - LVL_ONE));

   assert_push_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rd && !full) |=> (level == $past(level) + LVL_ONE));

   assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rd && !empty) |=> $stable(level));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rd && full) |=> (!ovf_lost && full));

   assert_drop_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !rd) |=> (ovf_lost && full));

   assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && empty && !wr) |=> empty);

   assert_empty_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && empty) |=> (level == LVL_ONE));

endmodule

// File: rtl/shift_result_fifo.sv
module shift_result_fifo
   import sdf_pkg::*;
#(
   parameter int unsigned VAL_W = SDF_DEF_VAL_W,
   parameter int unsigned DEPTH = SDF_DEF_DEPTH,
   localparam int unsigned WORD_W = VAL_W + 1,
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic [VAL_W-1:0] res_val,
   input  logic             res_oor,
   input  logic             rd_strobe,
   output logic [VAL_W-1:0] bot_val,
   output logic             bot_oor,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             ovf_lost
);

   initial begin
      assert (DEPTH >= 2) else $error("shift_result_fifo: DEPTH must be at least 2");
      assert (VAL_W >= 1) else $error("shift_result_fifo: VAL_W must be at least 1");
   end

   sdf_op_e          op;
   logic [LVL_W-1:0] load_idx;
   logic [WORD_W-1:0] din;
   logic [WORD_W-1:0] slot [DEPTH+1];

   assign din = {res_oor, res_val};

   sdf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (res_valid),
      .rd       (rd_strobe),
      .level    (level),
      .empty    (empty),
      .full     (full),
      .ovf_lost (ovf_lost),
      .op       (op),
      .load_idx (load_idx)
   );

   // zeros enter above the highest slot, so vacated slots read as zero
   assign slot[DEPTH] = '0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic load_here;
      assign load_here = op_loads(op) && (load_idx == LVL_W'(i));
      sdf_cell #(.WORD_W(WORD_W)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .shift (op_pops(op)),
         .load  (load_here),
         .upper (slot[i+1]),
         .din   (din),
         .q     (slot[i])
      );
   end

   assign {bot_oor, bot_val} = empty ? '0 : slot[0];

   assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && level >= LVL_W'(2)) |=> ({bot_oor, bot_val} == $past(slot[1])));

   assert_bottom_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strobe && !empty) |=> $stable({bot_oor, bot_val}));

   assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> ({bot_oor, bot_val} == '0));

   assert_load_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && empty) |=> ({bot_oor, bot_val} == $past(din)));

endmodule

// File: tb/shift_result_fifo_bench.sv
module shift_result_fifo_bench;

   localparam int CLK_PERIOD = 10;
   localparam int VAL_W = 12;
   localparam int DEPTH = 8;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             res_valid = 1'b0;
   logic [VAL_W-1:0] res_val = '0;
   logic             res_oor = 1'b0;
   logic             rd_strobe = 1'b0;
   logic [VAL_W-1:0] bot_val;
   logic             bot_oor;
   logic [LVL_W-1:0] level;
   logic             empty;
   logic             full;
   logic             ovf_lost;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [VAL_W:0] exp_q[$];
   bit             exp_ovf = 1'b0;
   string          cur_req = "R1";
   event           sample_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   shift_result_fifo #(.VAL_W(VAL_W), .DEPTH(DEPTH)) u_shift_result_fifo (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_val(res_val),
      .res_oor(res_oor), .rd_strobe(rd_strobe), .bot_val(bot_val),
      .bot_oor(bot_oor), .level(level), .empty(empty), .full(full),
      .ovf_lost(ovf_lost)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: compares the ports against the scoreboard, pops on a read
   always @(sample_ev) begin
      int sz;
      sz = exp_q.size();
      chk(cur_req, "level", int'(level), sz);
      chk("R8", "empty", int'(empty), int'(sz == 0));
      chk("R8", "full", int'(full), int'(sz == DEPTH));
      chk("R6", "ovf_lost", int'(ovf_lost), int'(exp_ovf));
      if (sz == 0)
         chk("R7", "bottom word when empty", int'({bot_oor, bot_val}), 0);
      else if (rd_strobe)
         chk(cur_req, "read word (R2 flag, R4 order)", int'({bot_oor, bot_val}), int'(exp_q.pop_front()));
      else
         chk(cur_req, "bottom word", int'({bot_oor, bot_val}), int'(exp_q[0]));
      // remaining model update for this edge (pop already done above)
      if (rd_strobe) exp_ovf = 1'b0;
      if (res_valid) begin
         if (exp_q.size() < DEPTH) exp_q.push_back({res_oor, res_val});
         else if (!rd_strobe) exp_ovf = 1'b1;
      end
   end

   // driver: applies one cycle of stimulus, triggers the monitor, waits for the edge
   task automatic cyc(input string req, input bit wr, input logic [VAL_W-1:0] v,
                      input bit oor, input bit rd);
      @(negedge clk);
      cur_req   = req;
      res_valid = wr;
      res_val   = v;
      res_oor   = oor;
      rd_strobe = rd;
      #(CLK_PERIOD/4);
      ->sample_ev;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #(CLK_PERIOD/4);
      chk("R1", "level", int'(level), 0);
      chk("R1", "empty", int'(empty), 1);
      chk("R1", "full", int'(full), 0);
      chk("R1", "ovf_lost", int'(ovf_lost), 0);
      chk("R1", "bottom word", int'({bot_oor, bot_val}), 0);

      // R7: read an empty queue
      cyc("R7", 0, '0, 0, 1);
      cyc("R7", 0, '0, 0, 0);

      // R2, R3: small burst with mixed flags, then R4 drain
      cyc("R3", 1, 12'h123, 0, 0);
      cyc("R2", 1, 12'hFFF, 1, 0);
      cyc("R3", 1, 12'h0A5, 0, 0);
      cyc("R3", 0, '0, 0, 0);
      for (int k = 0; k < 4; k++) cyc("R4", 0, '0, 0, 1);

      // R10: load and read together while empty
      cyc("R10", 1, 12'h777, 1, 1);
      cyc("R10", 0, '0, 0, 0);

      // R8: fill to the top, R6: extra load dropped and flag held
      for (int k = 0; k < DEPTH; k++) cyc("R8", 1, VAL_W'(12'h200 + k), k[0], 0);
      cyc("R6", 1, 12'hBAD, 1, 0);
      cyc("R6", 0, '0, 0, 0);
      cyc("R6", 1, 12'hBAD, 0, 0);
      cyc("R6", 0, '0, 0, 1);
      cyc("R6", 0, '0, 0, 0);

      // R5: combined at partial level
      cyc("R5", 1, 12'h3C3, 0, 1);
      cyc("R5", 1, 12'h3C4, 1, 1);
      cyc("R3", 1, 12'h3C5, 0, 0);
      // R9: combined at full
      cyc("R9", 1, 12'h4D4, 1, 1);
      cyc("R9", 0, '0, 0, 0);
      for (int k = 0; k < DEPTH + 1; k++) cyc("R4", 0, '0, 0, 1);

      // mixed pseudo-random traffic
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc("R5", lfsr[0] | lfsr[3], lfsr[15:4], lfsr[2], lfsr[1] & lfsr[5]);
      end
      for (int k = 0; k < DEPTH + 1; k++) cyc("R4", 0, '0, 0, 1);
      cyc("R7", 0, '0, 0, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule